// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table Controller

This block holds the per-function interrupt vector state of a PCIe-style endpoint. Each vector has a table entry with a 64-bit message address, a 32-bit message data word and a per-vector mask bit. A pending bit array records requests that could not be delivered. Software reaches the table and the pending array through a 32-bit little-endian register port that covers a 4096-byte region. The table sits in the lower half of the region and the pending array starts at byte offset 2048.

Two control bits act at function level: an enable bit and a mask-all bit. Either one can hold back every vector. The device logic raises one request line per vector. An unmasked request becomes a memory-write message on a valid/ready output. A masked request is kept as a pending bit and is sent later, once the vector becomes unmasked.

Each vector also has a use count that the device raises and lowers. The block drops requests to a vector whose count is zero.

Top module: `msix_vec_ctrl`

## Requirements
- R1: After reset every table entry holds zero address and zero data with its mask bit set, the enable and mask-all bits are 0, all pending bits are 0 and `msg_valid` is 0.
- R2: Entry v occupies bytes 16v to 16v+15. Word offset 0 holds address bits 31:0, offset 4 holds address bits 63:32, offset 8 holds the data and offset 12 holds the mask in bit 0 (other bits read 0). Writes to an entry read back unchanged, and entries at or beyond the vector count read 0.
- R3: An access takes effect only when all four byte enables are set and address bits 1:0 are zero. Any other write is ignored, and any other read returns 0.
- R4: The pending array at offset 2048 is read-only. Vector v is bit (v mod 32) of 32-bit word (v / 32), which is bit (v mod 8) of byte (v / 8). Bits and words beyond the vector count read 0, and writes to the array have no effect.
- R5: The function mask is active while enable is 0 or mask-all is 1. A vector is masked when its own mask bit is set or the function mask is active.
- R6: A request on an unmasked vector with a nonzero use count produces a message carrying {address high, address low} and the data. `msg_valid` rises one cycle after the clock edge that samples the request, and no pending bit remains set afterwards.
- R7: A request on a masked vector with a nonzero use count sets that vector's pending bit and produces no message.
- R8: When a pending vector becomes unmasked, through its own mask bit or through the function mask, its pending bit clears and its message is sent.
- R9: A request to a vector with use count zero is dropped. A decrement that brings the count to zero clears the pending bit. A decrement at zero has no effect.
- R10: When several vectors are deliverable together, the lowest-numbered vector is sent first.
- R11: While `msg_valid` is 1 and `msg_ready` is 0, the message address and data hold steady and `msg_valid` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (read data is combinational) |
| reg_addr | input | AW (12) | Byte address inside the region |
| reg_be | input | 4 | Byte enables, must be all ones |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data |
| ctl_wr | input | 1 | Control write strobe |
| ctl_en_wdata | input | 1 | New enable value |
| ctl_maskall_wdata | input | 1 | New mask-all value |
| ctl_en | output | 1 | Current enable bit |
| ctl_maskall | output | 1 | Current mask-all bit |
| irq_req | input | NUM_VEC | One request pulse per vector |
| use_inc | input | 1 | Increment use count of `use_vec` |
| use_dec | input | 1 | Decrement use count of `use_vec` |
| use_vec | input | VEC_W | Vector whose use count changes |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted by downstream |
| msg_addr | output | 64 | Message target address |
| msg_data | output | 32 | Message payload |

## Verification
The bench targets masked requests that must stay pending across a mask-all period and then drain in ascending order. A design with the wrong priority would send vector 4 ahead of vector 1. A design that lost the deferred request would send nothing. The bench also holds `msg_ready` low while the mask state changes, which exposes an output that drops or alters a message it is already offering. It further checks a wrong byte-enable write, a write into the read-only pending array, and a request to an unused vector. A design that mishandled any of these would show altered read-back values or a spurious pending bit. Finally, it drops a pending vector's use count to zero to confirm the deferred message is discarded rather than sent later.

// File: rtl/msix_pkg.sv
package msix_pkg;
   typedef enum logic [1:0] {
      WSEL_ADDR_LO = 2'd0,
      WSEL_ADDR_HI = 2'd1,
      WSEL_DATA    = 2'd2,
      WSEL_CTRL    = 2'd3
   } word_sel_e;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/msix_table.sv
module msix_table
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int VEC_W = idx_width(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [VEC_W-1:0]   wr_vec,
   input  word_sel_e          wr_sel,
   input  logic [31:0]        wr_data,
   input  logic [VEC_W-1:0]   rd_vec,
   input  word_sel_e          rd_sel,
   output logic [31:0]        rd_data,
   input  logic [VEC_W-1:0]   sel_vec,
   output logic [63:0]        sel_addr,
   output logic [31:0]        sel_data,
   output logic [NUM_VEC-1:0] entry_mask
);
   logic [31:0] lo_q   [NUM_VEC];
   logic [31:0] hi_q   [NUM_VEC];
   logic [31:0] data_q [NUM_VEC];
   logic [NUM_VEC-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            lo_q[v]   <= '0;
            hi_q[v]   <= '0;
            data_q[v] <= '0;
         end
         mask_q <= '1;
      end else if (wr_en) begin
         unique case (wr_sel)
            WSEL_ADDR_LO: lo_q[wr_vec]   <= wr_data;
            WSEL_ADDR_HI: hi_q[wr_vec]   <= wr_data;
            WSEL_DATA:    data_q[wr_vec] <= wr_data;
            WSEL_CTRL:    mask_q[wr_vec] <= wr_data[0];
         endcase
      end
   end

   always_comb begin
      unique case (rd_sel)
         WSEL_ADDR_LO: rd_data = lo_q[rd_vec];
         WSEL_ADDR_HI: rd_data = hi_q[rd_vec];
         WSEL_DATA:    rd_data = data_q[rd_vec];
         WSEL_CTRL:    rd_data = {31'b0, mask_q[rd_vec]};
      endcase
   end

   assign sel_addr   = {hi_q[sel_vec], lo_q[sel_vec]};
   assign sel_data   = data_q[sel_vec];
   assign entry_mask = mask_q;
endmodule

// File: rtl/msix_pend.sv
module msix_pend
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int USE_W   = 4,
   localparam int VEC_W = idx_width(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] req,
   input  logic [NUM_VEC-1:0] grant,
   input  logic               use_inc,
   input  logic               use_dec,
   input  logic [VEC_W-1:0]   use_vec,
   output logic [NUM_VEC-1:0] pend,
   output logic [NUM_VEC-1:0] used
);
   logic [USE_W-1:0]   cnt_q [NUM_VEC];
   logic [NUM_VEC-1:0] pend_q;
   logic [NUM_VEC-1:0] drop_clr;
   logic               do_inc, do_dec;

   assign do_inc = use_inc && !use_dec;
   assign do_dec = use_dec && !use_inc;

   always_comb begin
      for (int v = 0; v < NUM_VEC; v++) begin
         used[v]     = (cnt_q[v] != '0);
         drop_clr[v] = do_dec && (int'(use_vec) == v) && (cnt_q[v] == USE_W'(1));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) cnt_q[v] <= '0;
         pend_q <= '0;
      end else begin
         pend_q <= (pend_q & ~grant & ~drop_clr) | (req & used);
         if (do_inc && cnt_q[use_vec] != '1)
            cnt_q[use_vec] <= cnt_q[use_vec] + USE_W'(1);
         else if (do_dec && cnt_q[use_vec] != '0)
            cnt_q[use_vec] <= cnt_q[use_vec] - USE_W'(1);
      end
   end

   assign pend = pend_q;

   AST_PEND_NEEDS_USE: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q & ~used) == '0); // R9
   AST_GRANT_FROM_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & ~pend_q) == '0); // R8
endmodule

// File: rtl/msix_arb.sv
module msix_arb
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8,
   localparam int VEC_W = idx_width(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] cand,
   output logic [VEC_W-1:0]   pick,
   input  logic [63:0]        sel_addr,
   input  logic [31:0]        sel_data,
   output logic [NUM_VEC-1:0] grant,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   logic found, slot_free, load;

   generate
      if (NUM_VEC == 1) begin : g_single
         assign pick  = '0;
         assign found = cand[0];
      end else begin : g_scan
         always_comb begin
            pick  = '0;
            found = 1'b0;
            for (int v = NUM_VEC - 1; v >= 0; v--) begin
               if (cand[v]) begin
                  pick  = VEC_W'(v);
                  found = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign slot_free = !msg_valid || msg_ready;
   assign load      = found && slot_free;
   assign grant     = load ? (NUM_VEC'(1) << pick) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
      end else if (load) begin
         msg_valid <= 1'b1;
         msg_addr  <= sel_addr;
         msg_data  <= sel_data;
      end else if (msg_ready) begin
         msg_valid <= 1'b0;
      end
   end

   AST_MSG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ready |=> msg_valid && $stable(msg_addr) && $stable(msg_data)); // R11
   AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R10
   AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
      grant != '0 |-> (cand & (grant - NUM_VEC'(1))) == '0); // R10
endmodule

// File: rtl/msix_vec_ctrl.sv
module msix_vec_ctrl
   import msix_pkg::*;
#(
   parameter int NUM_VEC = 8,
   parameter int USE_W   = 4,
   parameter int AW      = 12,
   localparam int VEC_W  = idx_width(NUM_VEC)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_wr,
   input  logic               reg_rd,
   input  logic [AW-1:0]      reg_addr,
   input  logic [3:0]         reg_be,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               ctl_wr,
   input  logic               ctl_en_wdata,
   input  logic               ctl_maskall_wdata,
   output logic               ctl_en,
   output logic               ctl_maskall,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic               use_inc,
   input  logic               use_dec,
   input  logic [VEC_W-1:0]   use_vec,
   output logic               msg_valid,
   input  logic               msg_ready,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data
);
   localparam int PBA_BITS  = ((NUM_VEC + 63) / 64) * 64;
   localparam int PBA_WORDS = PBA_BITS / 32;
   localparam int SLOT_W    = AW - 5;

   generate
      if (NUM_VEC < 1 || NUM_VEC * 16 > (1 << (AW - 1))) begin : g_bad_count
         $error("vector table does not fit the lower half of the region");
      end
      if (USE_W < 1 || VEC_W > SLOT_W) begin : g_bad_width
         $error("use counter or vector index width out of range");
      end
   endgenerate

   logic               acc_ok, in_pba, slot_ok, tbl_wr;
   logic [SLOT_W-1:0]  slot;
   logic [VEC_W-1:0]   vec_idx, pick;
   logic [31:0]        tbl_rdata;
   logic [63:0]        sel_addr;
   logic [31:0]        sel_data;
   logic [NUM_VEC-1:0] entry_mask, eff_mask, pend, used, grant, cand;
   logic [PBA_BITS-1:0] pba_img;
   logic               en_q, maskall_q, func_mask;

   assign acc_ok  = (reg_be == 4'hF) && (reg_addr[1:0] == 2'b00);
   assign in_pba  = reg_addr[AW-1];
   assign slot    = reg_addr[AW-2:4];
   assign slot_ok = int'(slot) < NUM_VEC;
   assign vec_idx = slot[VEC_W-1:0];
   assign tbl_wr  = reg_wr && acc_ok && !in_pba && slot_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         maskall_q <= 1'b0;
      end else if (ctl_wr) begin
         en_q      <= ctl_en_wdata;
         maskall_q <= ctl_maskall_wdata;
      end
   end

   assign ctl_en      = en_q;
   assign ctl_maskall = maskall_q;
   assign func_mask   = !en_q || maskall_q;
   assign eff_mask    = entry_mask | {NUM_VEC{func_mask}};
   assign cand        = pend & ~eff_mask;

   msix_table #(.NUM_VEC(NUM_VEC)) u_table (
      .clk(clk), .rst_n(rst_n),
      .wr_en(tbl_wr), .wr_vec(vec_idx), .wr_sel(word_sel_e'(reg_addr[3:2])),
      .wr_data(reg_wdata),
      .rd_vec(vec_idx), .rd_sel(word_sel_e'(reg_addr[3:2])), .rd_data(tbl_rdata),
      .sel_vec(pick), .sel_addr(sel_addr), .sel_data(sel_data),
      .entry_mask(entry_mask)
   );

   msix_pend #(.NUM_VEC(NUM_VEC), .USE_W(USE_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .req(irq_req), .grant(grant),
      .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
      .pend(pend), .used(used)
   );

   msix_arb #(.NUM_VEC(NUM_VEC)) u_arb (
      .clk(clk), .rst_n(rst_n), .cand(cand), .pick(pick),
      .sel_addr(sel_addr), .sel_data(sel_data), .grant(grant),
      .msg_valid(msg_valid), .msg_ready(msg_ready),
      .msg_addr(msg_addr), .msg_data(msg_data)
   );

   always_comb begin
      pba_img = '0;
      pba_img[NUM_VEC-1:0] = pend;
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd && acc_ok) begin
         if (in_pba) begin
            for (int w = 0; w < PBA_WORDS; w++)
               if (int'(reg_addr[AW-2:2]) == w) reg_rdata = pba_img[w*32 +: 32];
         end else if (slot_ok) begin
            reg_rdata = tbl_rdata;
         end
      end
   end

   AST_NO_SEND_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (grant & eff_mask) == '0); // R7
   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q && !msg_valid |=> !msg_valid); // R5
endmodule

// File: tb/msix_vec_ctrl_bench.sv
module msix_vec_ctrl_bench;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 0, reg_rd = 0;
   logic [11:0] reg_addr = '0;
   logic [3:0]  reg_be = 4'hF;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ctl_wr = 0, ctl_en_wdata = 0, ctl_maskall_wdata = 0;
   logic        ctl_en, ctl_maskall;
   logic [NV-1:0] irq_req = '0;
   logic        use_inc = 0, use_dec = 0;
   logic [2:0]  use_vec = '0;
   logic        msg_valid, msg_ready = 1'b1;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;

   int n_run = 0, n_fail = 0;

   always #2 clk = ~clk;

   msix_vec_ctrl u_msix_vec_ctrl (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_be(reg_be),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ctl_wr(ctl_wr), .ctl_en_wdata(ctl_en_wdata), .ctl_maskall_wdata(ctl_maskall_wdata),
      .ctl_en(ctl_en), .ctl_maskall(ctl_maskall),
      .irq_req(irq_req), .use_inc(use_inc), .use_dec(use_dec), .use_vec(use_vec),
      .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr), .msg_data(msg_data)
   );

   // behavioural reference state
   bit [31:0] m_lo [NV];
   bit [31:0] m_hi [NV];
   bit [31:0] m_dt [NV];
   bit        m_mask [NV];
   bit        m_pend [NV];
   int        m_use [NV];
   bit        m_en, m_ma, m_ov;
   bit [63:0] m_oa;
   bit [31:0] m_od;
   int        pick;
   bit        fm;

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NV; v++) begin
            m_lo[v] = 0; m_hi[v] = 0; m_dt[v] = 0; m_mask[v] = 1; m_pend[v] = 0; m_use[v] = 0;
         end
         m_en = 0; m_ma = 0; m_ov = 0; m_oa = 0; m_od = 0;
      end else begin
         fm = !m_en || m_ma;
         pick = -1;
         for (int v = NV - 1; v >= 0; v--)
            if (m_pend[v] && !(m_mask[v] || fm)) pick = v;
         if (!m_ov || msg_ready) begin
            if (pick >= 0) begin
               m_ov = 1; m_oa = {m_hi[pick], m_lo[pick]}; m_od = m_dt[pick]; m_pend[pick] = 0;
            end else m_ov = 0;
         end
         if (use_dec && !use_inc && m_use[use_vec] == 1) m_pend[use_vec] = 0;
         for (int v = 0; v < NV; v++)
            if (irq_req[v] && m_use[v] != 0) m_pend[v] = 1;
         if (use_inc && !use_dec && m_use[use_vec] < 15) m_use[use_vec]++;
         else if (use_dec && !use_inc && m_use[use_vec] > 0) m_use[use_vec]--;
         if (reg_wr && reg_be == 4'hF && reg_addr[1:0] == 0 && !reg_addr[11]
             && int'(reg_addr[10:4]) < NV) begin
            case (reg_addr[3:2])
               2'd0: m_lo[reg_addr[6:4]] = reg_wdata;
               2'd1: m_hi[reg_addr[6:4]] = reg_wdata;
               2'd2: m_dt[reg_addr[6:4]] = reg_wdata;
               default: m_mask[reg_addr[6:4]] = reg_wdata[0];
            endcase
         end
         if (ctl_wr) begin m_en = ctl_en_wdata; m_ma = ctl_maskall_wdata; end
      end
   end

   function automatic bit [31:0] mread(input bit [11:0] a, input bit [3:0] be);
      bit [31:0] r = 0;
      if (be != 4'hF || a[1:0] != 0) return 0;
      if (a[11]) begin
         if (a[10:2] == 0)
            for (int v = 0; v < NV; v++) r[v] = m_pend[v];
         return r;
      end
      if (int'(a[10:4]) >= NV) return 0;
      case (a[3:2])
         2'd0: r = m_lo[a[6:4]];
         2'd1: r = m_hi[a[6:4]];
         2'd2: r = m_dt[a[6:4]];
         default: r = {31'b0, m_mask[a[6:4]]};
      endcase
      return r;
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the reference (R6, R11)
   always @(negedge clk) begin
      if (rst_n) begin
         check("R6 msg_valid", 64'(msg_valid), 64'(m_ov));
         if (m_ov) begin
            check("R6 msg_addr", msg_addr, m_oa);
            check("R11 msg_data", 64'(msg_data), 64'(m_od));
         end
      end
   end

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d; reg_be = be;
      @(negedge clk);
      reg_wr = 0; reg_be = 4'hF;
   endtask

   task automatic rd(input string req, input logic [11:0] a, input logic [3:0] be = 4'hF);
      @(negedge clk);
      reg_rd = 1; reg_addr = a; reg_be = be;
      #1;
      check(req, 64'(reg_rdata), 64'(mread(a, be)));
      reg_rd = 0; reg_be = 4'hF;
   endtask

   task automatic rd_lit(input string req, input logic [11:0] a, input logic [31:0] exp);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      #1;
      check(req, 64'(reg_rdata), 64'(exp));
      reg_rd = 0;
   endtask

   task automatic ctl(input logic en, input logic ma);
      @(negedge clk);
      ctl_wr = 1; ctl_en_wdata = en; ctl_maskall_wdata = ma;
      @(negedge clk);
      ctl_wr = 0;
   endtask

   task automatic req(input logic [NV-1:0] m);
      @(negedge clk);
      irq_req = m;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic use_op(input logic inc, input logic [2:0] v);
      @(negedge clk);
      use_inc = inc; use_dec = !inc; use_vec = v;
      @(negedge clk);
      use_inc = 0; use_dec = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      idle(4);
      rst_n = 1;
      idle(1);
      // R1 reset state
      check("R1 ctl_en", 64'(ctl_en), 0);
      check("R1 ctl_maskall", 64'(ctl_maskall), 0);
      check("R1 msg_valid", 64'(msg_valid), 0);
      for (int v = 0; v < NV; v++) begin
         rd_lit("R1 mask set", 12'(v * 16 + 12), 32'h1);
         rd_lit("R1 data zero", 12'(v * 16 + 8), 32'h0);
      end
      rd_lit("R1 pba zero", 12'h800, 32'h0);

      // R2 program table
      for (int v = 0; v < NV; v++) begin
         wr(12'(v * 16 + 0), 32'hA000_0000 + 32'(v * 16));
         wr(12'(v * 16 + 4), 32'h0000_00F0 + 32'(v));
         wr(12'(v * 16 + 8), 32'hD000_0000 + 32'(v));
      end
      for (int v = 0; v < NV; v++) begin
         rd("R2 addr lo", 12'(v * 16));
         rd("R2 addr hi", 12'(v * 16 + 4));
         rd("R2 data", 12'(v * 16 + 8));
      end
      rd_lit("R2 lit", 12'h038, 32'hD000_0003);
      rd_lit("R2 beyond count", 12'h088, 32'h0);

      // R3 bad size accesses
      wr(12'h018, 32'hBAD0_0001, 4'h3);
      rd_lit("R3 partial write ignored", 12'h018, 32'hD000_0001);
      wr(12'h019, 32'hBAD0_0002);
      rd_lit("R3 misaligned write ignored", 12'h018, 32'hD000_0001);
      rd("R3 partial read zero", 12'h018, 4'h1);

      // enable vectors; 6 is never used
      for (int v = 0; v < NV; v++) if (v != 6) use_op(1, 3'(v));
      ctl(1, 0);
      check("R5 ctl_en", 64'(ctl_en), 1);
      for (int v = 0; v < NV; v++) if (v != 2) wr(12'(v * 16 + 12), 32'h0);

      // R6 unmasked delivery
      req(8'h08);
      idle(3);
      rd_lit("R6 no pending left", 12'h800, 32'h0);

      // R7 masked request
      req(8'h04);
      idle(3);
      rd_lit("R7 pending bit 2", 12'h800, 32'h4);
      check("R7 no message", 64'(msg_valid), 0);

      // R8 unmask entry
      wr(12'h02C, 32'h0);
      idle(1);
      check("R8 deferred msg", 64'(msg_data), 64'(32'hD000_0002));
      idle(2);
      rd_lit("R8 pending cleared", 12'h800, 32'h0);

      // R4 / R10 / R11 mask-all then drain with backpressure
      ctl(1, 1);
      req(8'h12);
      idle(3);
      rd_lit("R4 pending 1 and 4", 12'h800, 32'h12);
      wr(12'h800, 32'h0);
      rd_lit("R4 pba write ignored", 12'h800, 32'h12);
      rd_lit("R4 pad word zero", 12'h804, 32'h0);
      msg_ready = 0;
      ctl(1, 0);
      idle(2);
      check("R10 lowest first", 64'(msg_data), 64'(32'hD000_0001));
      idle(4);
      check("R11 held valid", 64'(msg_valid), 1);
      check("R11 held data", 64'(msg_data), 64'(32'hD000_0001));
      msg_ready = 1;
      idle(1);
      check("R10 next vector", 64'(msg_data), 64'(32'hD000_0004));
      idle(3);

      // R9 unused vector and use-count drop
      req(8'h40);
      idle(3);
      rd_lit("R9 unused dropped", 12'h800, 32'h0);
      wr(12'h07C, 32'h1);
      req(8'h80);
      idle(2);
      rd_lit("R9 pending 7", 12'h800, 32'h80);
      use_op(0, 3'd7);
      idle(1);
      rd_lit("R9 drop clears", 12'h800, 32'h0);
      wr(12'h07C, 32'h0);
      idle(3);
      check("R9 no late message", 64'(msg_valid), 0);
      use_op(0, 3'd7);
      use_op(0, 3'd6);

      // R5 function disable then re-enable, with simultaneous requests
      ctl(0, 0);
      req(8'h21);
      idle(3);
      rd_lit("R5 disabled pends", 12'h800, 32'h21);
      ctl(1, 0);
      idle(6);
      rd_lit("R5 drained", 12'h800, 32'h0);

      idle(4);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule